// File: doc/BRIEF.md
# Byte-wide parallel EEPROM device model

This block is a synthesizable model of the device side of a byte-wide parallel EEPROM holding 2K bytes. It runs on a fast system clock. The active-low chip-select, output-enable and write-strobe inputs pass through two-flop synchronisers, and the block decodes them into read, write and idle. The address bus and data bus go through matching two-stage pipes, so the values seen at a strobe edge line up with that edge.

A write takes its address when the combined write condition begins, which is the later of the two falling strobes. It takes its data when that condition ends, which is the earlier of the two rising strobes. The block then runs a self-timed programming period. During that period a read of the location being written returns polling status, with bit 7 inverted. A read of any other location returns all ones. New write attempts are ignored while programming runs.

Writes are also blocked in three cases:
- the strobe low time is shorter than the glitch limit;
- the supply-good flag is low;
- the power-on hold-off window has not yet run out after the supply became good.

The output data and its bus-enable go to an external tri-state buffer.

Top module: `eeprom_dev`

## Requirements
- R1: `dout_en_o` is high only when, three clock edges earlier, `ce_n_i` was 0, `oe_n_i` was 0 and `we_n_i` was 1. In that case `dout_o` carries the stored byte of `addr_i` once programming is idle. In every other strobe combination `dout_en_o` is 0, including all three strobes low.
- R2: A write condition is `ce_n_i`=0, `we_n_i`=0 and `oe_n_i`=1, held for at least `GLITCH_CYC` cycles. It stores `din_i` at `addr_i`, and the stored value is read back once programming ends. This holds at address 0 and at address 2047.
- R3: The write address is the one present when the second of `we_n_i`/`ce_n_i` falls. Address changes before that edge have no effect, whichever of the two strobes falls last.
- R4: The write data is the one present when the first of `we_n_i`/`ce_n_i` rises. Data changes after that edge are not stored, whichever of the two strobes rises first.
- R5: After a write is accepted, programming stays busy for `PROG_CYC` cycles. Write attempts during that time change no location.
- R6: While busy, a read of the address being written returns `{~d[7], 7'b1111111}`, where d is the data being written. A read of any other address returns 8'hFF. True data returns after programming ends.
- R7: While `vgood_i` is 0, no write is accepted and programming does not start.
- R8: Each time `vgood_i` rises, writes stay blocked for `POR_CYC` cycles. After that window they are accepted again.
- R9: A write condition lasting fewer than `GLITCH_CYC` cycles starts no write. One lasting exactly `GLITCH_CYC` cycles does start a write.
- R10: During and right after reset, `dout_en_o` is 0 and no programming is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 11 | Byte address |
| ce_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write strobe, active low |
| vgood_i | input | 1 | Supply above write-inhibit level |
| din_i | input | 8 | Write data |
| dout_o | output | 8 | Read data |
| dout_en_o | output | 1 | Drive enable for the data bus buffer |

## Verification
Writes are tried in four strobe orders: write-strobe-controlled, chip-select-controlled, chip-select falling first and write-strobe falling first. Between the two edges the address or data is moved, so a wrong choice of capture edge lands the byte at a different location or stores the wrong value. Reads made during programming use a byte with bit 7 set, so polling status differs both from true data and from the all-ones answer for other addresses. Blocked writes are run while the supply is low, inside the power-on window and with a pulse one cycle short of the glitch limit. Each blocked write is followed at once by a read of an unrelated location, which exposes any unwanted busy state, and later by a read of the target location.

// File: rtl/eeprom_dev.sv
module eeprom_dev #(
  parameter int AW         = 11,
  parameter int DW         = 8,
  parameter int PROG_CYC   = 2_000_000,
  parameter int POR_CYC    = 2_000_000,
  parameter int GLITCH_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          we_n_i,
  input  logic          vgood_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          dout_en_o
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = $clog2(PROG_CYC + 1);
  localparam int QW    = $clog2(POR_CYC + 1);
  localparam int GW    = $clog2(GLITCH_CYC + 1);

  logic [1:0]    ce_sy, oe_sy, we_sy, vg_sy;
  logic [AW-1:0] a_p1, a_p2, pa_q, wa_q;
  logic [DW-1:0] d_p1, d_p2, wd_q;
  logic [PW-1:0] prog_cnt;
  logic [QW-1:0] por_cnt;
  logic [GW-1:0] gl_cnt;
  logic          wr_q;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_sy <= 2'b11;
      oe_sy <= 2'b11;
      we_sy <= 2'b11;
      vg_sy <= 2'b00;
      a_p1  <= '0;
      a_p2  <= '0;
      d_p1  <= '0;
      d_p2  <= '0;
    end else begin
      ce_sy <= {ce_sy[0], ce_n_i};
      oe_sy <= {oe_sy[0], oe_n_i};
      we_sy <= {we_sy[0], we_n_i};
      vg_sy <= {vg_sy[0], vgood_i};
      a_p1  <= addr_i;
      a_p2  <= a_p1;
      d_p1  <= din_i;
      d_p2  <= d_p1;
    end
  end

  wire ce_s    = ce_sy[1];
  wire oe_s    = oe_sy[1];
  wire we_s    = we_sy[1];
  wire vg_s    = vg_sy[1];
  wire wr_lo   = ~ce_s & ~we_s & oe_s;
  wire rd      = ~ce_s & ~oe_s & we_s;
  wire busy    = prog_cnt != '0;
  wire inhibit = ~vg_s | (por_cnt != '0);
  wire ok_len  = gl_cnt == GW'(GLITCH_CYC);
  wire commit  = wr_q & ~wr_lo & ok_len & ~busy & ~inhibit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      gl_cnt <= '0;
      pa_q   <= '0;
    end else begin
      wr_q <= wr_lo;
      if (!wr_lo)
        gl_cnt <= '0;
      else if (!ok_len)
        gl_cnt <= gl_cnt + GW'(1);
      if (wr_lo && !wr_q)
        pa_q <= a_p2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      por_cnt <= QW'(POR_CYC);
    else if (!vg_s)
      por_cnt <= QW'(POR_CYC);
    else if (por_cnt != '0)
      por_cnt <= por_cnt - QW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_cnt <= '0;
      wa_q     <= '0;
      wd_q     <= '0;
    end else if (commit) begin
      prog_cnt <= PW'(PROG_CYC);
      wa_q     <= pa_q;
      wd_q     <= d_p2;
    end else if (busy) begin
      prog_cnt <= prog_cnt - PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (prog_cnt == PW'(1))
      mem[wa_q] <= wd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_o    <= '0;
      dout_en_o <= 1'b0;
    end else begin
      dout_en_o <= rd;
      if (!busy)
        dout_o <= mem[a_p2];
      else if (a_p2 == wa_q)
        dout_o <= {~wd_q[DW-1], {(DW-1){1'b1}}};
      else
        dout_o <= '1;
    end
  end
endmodule

module eeprom_dev_chk #(
  parameter int AW      = 11,
  parameter int DW      = 8,
  parameter int POR_CYC = 2_000_000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n_i,
  input logic          oe_n_i,
  input logic          we_n_i,
  input logic          vgood_i,
  input logic          dout_en_o,
  input logic          busy,
  input logic [AW-1:0] wa_q,
  input logic [DW-1:0] wd_q
);
  int unsigned vg_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      vg_run <= 0;
    else if (!vgood_i)
      vg_run <= 0;
    else if (vg_run < POR_CYC + 8)
      vg_run <= vg_run + 1;
  end

  p_rd_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en_o |-> (!$past(ce_n_i, 3) && !$past(oe_n_i, 3) && $past(we_n_i, 3)));

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(wa_q) && $stable(wd_q)));

  p_supply_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(vgood_i, 3));

  p_por_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (vg_run >= POR_CYC));
endmodule

bind eeprom_dev eeprom_dev_chk #(.AW(AW), .DW(DW), .POR_CYC(POR_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .we_n_i(we_n_i),
  .vgood_i(vgood_i), .dout_en_o(dout_en_o), .busy(busy), .wa_q(wa_q), .wd_q(wd_q)
);

// File: tb/tb_eeprom_dev.sv
module tb_eeprom_dev;
  localparam int PROG = 200;
  localparam int POR  = 300;
  localparam int GL   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr = '0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vgood = 1'b1;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en;
  int          total = 0, bad = 0;
  logic        done = 1'b0;

  eeprom_dev #(.PROG_CYC(PROG), .POR_CYC(POR), .GLITCH_CYC(GL)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .we_n_i(we_n), .vgood_i(vgood), .din_i(din), .dout_o(dout), .dout_en_o(dout_en)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d, output logic en);
    @(negedge clk);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    repeat (4) @(negedge clk);
    d = dout; en = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [10:0] a, input logic [7:0] exp);
    logic [7:0] d;
    logic en;
    rd(a, d, en);
    chk(req, {7'd0, en}, 8'd1);
    chk(req, d, exp);
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d, input int lo);
    @(negedge clk);
    addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0;
    @(negedge clk);
    we_n = 1'b0;
    repeat (lo) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_prog();
    repeat (PROG + 10) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 en in reset", {7'd0, dout_en}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 en after reset", {7'd0, dout_en}, 8'd0);
    repeat (POR + 10) @(negedge clk);
  endtask

  task automatic t_basic();
    wr(11'h010, 8'hA5, 6); wait_prog();
    wr(11'h7FF, 8'h3C, 6); wait_prog();
    wr(11'h000, 8'h81, 6); wait_prog();
    rd_chk("R2 addr 0x010", 11'h010, 8'hA5);
    rd_chk("R2 top addr", 11'h7FF, 8'h3C);
    rd_chk("R2 addr 0", 11'h000, 8'h81);
  endtask

  task automatic t_gate();
    @(negedge clk); addr = 11'h010; ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 ce high", {7'd0, dout_en}, 8'd0);
    ce_n = 1'b0; oe_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 oe high", {7'd0, dout_en}, 8'd0);
    oe_n = 1'b0; we_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 all low", {7'd0, dout_en}, 8'd0);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (5) @(negedge clk);
    rd_chk("R1 unchanged after all low", 11'h010, 8'hA5);
  endtask

  task automatic t_poll();
    wr(11'h020, 8'hD2, 6);
    rd_chk("R6 poll own addr", 11'h020, 8'h7F);
    rd_chk("R6 other addr busy", 11'h010, 8'hFF);
    wait_prog();
    rd_chk("R6 true data after", 11'h020, 8'hD2);
  endtask

  task automatic t_busy();
    wr(11'h030, 8'h44, 6); wait_prog();
    wr(11'h031, 8'h99, 6);
    wr(11'h030, 8'h00, 6);
    repeat (PROG - 40) @(negedge clk);
    rd_chk("R5 still busy late", 11'h031, 8'h7F);
    wait_prog();
    rd_chk("R5 ignored write", 11'h030, 8'h44);
    rd_chk("R5 accepted write", 11'h031, 8'h99);
  endtask

  task automatic t_addr_late();
    wr(11'h040, 8'h11, 6); wait_prog();
    @(negedge clk); addr = 11'h040; din = 8'h77; oe_n = 1'b1; ce_n = 1'b0;
    repeat (3) @(negedge clk); addr = 11'h041;
    repeat (3) @(negedge clk); we_n = 1'b0;
    repeat (6) @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    wait_prog();
    @(negedge clk); addr = 11'h040; din = 8'h88; we_n = 1'b0;
    repeat (3) @(negedge clk); addr = 11'h042;
    repeat (3) @(negedge clk); ce_n = 1'b0;
    repeat (6) @(negedge clk); ce_n = 1'b1;
    @(negedge clk); we_n = 1'b1;
    wait_prog();
    rd_chk("R3 we falls last", 11'h041, 8'h77);
    rd_chk("R3 ce falls last", 11'h042, 8'h88);
    rd_chk("R3 early addr untouched", 11'h040, 8'h11);
  endtask

  task automatic t_data_early();
    @(negedge clk); addr = 11'h044; din = 8'h5C; oe_n = 1'b1; we_n = 1'b0;
    @(negedge clk); ce_n = 1'b0;
    repeat (6) @(negedge clk); ce_n = 1'b1;
    @(negedge clk); din = 8'hEE;
    repeat (3) @(negedge clk); we_n = 1'b1;
    wait_prog();
    @(negedge clk); addr = 11'h045; din = 8'h6D; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    repeat (6) @(negedge clk); we_n = 1'b1;
    @(negedge clk); din = 8'hEE;
    repeat (3) @(negedge clk); ce_n = 1'b1;
    wait_prog();
    rd_chk("R4 ce rises first", 11'h044, 8'h5C);
    rd_chk("R4 we rises first", 11'h045, 8'h6D);
  endtask

  task automatic t_glitch();
    wr(11'h050, 8'h0F, 6); wait_prog();
    wr(11'h050, 8'hF0, GL - 1);
    rd_chk("R9 short pulse not busy", 11'h010, 8'hA5);
    rd_chk("R9 short pulse no write", 11'h050, 8'h0F);
    wr(11'h050, 8'hF0, GL); wait_prog();
    rd_chk("R9 exact pulse writes", 11'h050, 8'hF0);
  endtask

  task automatic t_supply();
    wr(11'h060, 8'h12, 6); wait_prog();
    @(negedge clk); vgood = 1'b0;
    repeat (5) @(negedge clk);
    wr(11'h060, 8'h34, 6);
    rd_chk("R7 low supply not busy", 11'h010, 8'hA5);
    rd_chk("R7 low supply no write", 11'h060, 8'h12);
  endtask

  task automatic t_por();
    @(negedge clk); vgood = 1'b1;
    repeat (5) @(negedge clk);
    wr(11'h060, 8'h56, 6);
    rd_chk("R8 window not busy", 11'h010, 8'hA5);
    rd_chk("R8 window no write", 11'h060, 8'h12);
    repeat (POR + 10) @(negedge clk);
    wr(11'h060, 8'h56, 6); wait_prog();
    rd_chk("R8 write after window", 11'h060, 8'h56);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_gate();
    t_poll();
    t_busy();
    t_addr_late();
    t_data_early();
    t_glitch();
    t_supply();
    t_por();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule